// File: doc/BRIEF.md
# Predicated SIMD Lane Array

This block is a row of identical 16-bit execution lanes. All lanes are driven by a single instruction stream. Each accepted instruction goes to every lane in the same cycle. Each lane applies it to its own slice of state:

- a local vector memory of `DEPTH` words;
- a file of `NFLAGS` one-bit Boolean flags;
- a rotate register that links only to the lane on its right.

Word `a` of every lane together forms vector `a`, which has `LANES` components. Flag `f` of every lane together forms Boolean vector `f`.

The supported operations are:

- element-wise add and subtract, with the carry or borrow of each lane written to a flag;
- flag AND and OR;
- broadcast and lane-index loads;
- per-lane flag loads from an immediate mask;
- whole-vector rotation.

Any vector or flag write can be predicated on a selected flag, which gives a spatial "if": lanes whose flag is 0 keep their old destination value.

Rotation needs no crossbar. It is built from single-step moves over the neighbour links, so a rotate by `k` occupies the array for `k` cycles.

Instructions arrive on a valid/ready port. An instruction is taken on the rising edge where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the source holds all `in_*` fields stable. `in_ready` falls only while a rotation is shifting. `done` pulses for one cycle once the results of an instruction are visible. A combinational debug port reads any word or any flag vector.

Top module: `simd_lane_array`

## Requirements
- R1: After reset every memory word and every flag is 0, `in_ready` is 1 and `done` is 0.
- R2: Every instruction taken on an edge where `in_valid` and `in_ready` are high is executed by all lanes. Every opcode except ROT with a nonzero amount completes on that edge: `in_ready` stays 1 and `done` is 1 in the following cycle.
- R3: Opcode 1 (ADD) writes `(a+b) mod 65536` to vector `in_dst` and the carry-out of each lane to flag `in_fdst`.
- R4: Opcode 2 (SUB) writes `(a-b) mod 65536` to `in_dst` and writes the borrow to flag `in_fdst`. The borrow is 1 exactly when a < b unsigned.
- R5: Opcode 3 (FAND) and opcode 4 (FOR) write flag `in_fsa` AND or OR flag `in_fsb` into flag `in_fdst`, lane by lane.
- R6: Each load opcode writes as follows:

  | Opcode | Name | Target | Value written in lane i |
  |---|---|---|---|
  | 5 | LDI | vector `in_dst` | `in_imm` |
  | 6 | IDX | vector `in_dst` | i |
  | 7 | FLDI | flag `in_fdst` | bit (i mod 16) of `in_imm` |
- R7: With `in_pred_en`=1, the following opcodes are predicated: ADD, SUB, FAND, FOR, LDI, IDX and FLDI. A lane whose flag `in_pred_sel` is 0 leaves both its vector and its flag destinations unchanged. A lane whose flag is 1 behaves as in R3 to R6.
- R8: Opcode 8 (ROT) with amount k sets element i of `in_dst` to the old element (i+k) mod `LANES` of `in_src_a`, for all lanes. It is not predicated.
- R9: ROT with k>0 holds `in_ready` low for k cycles after it is taken, and `done` is 1 in the cycle `in_ready` returns. ROT with k=0 copies `in_src_a` to `in_dst` as a single-cycle instruction.
- R10: While `in_valid` is 0, no memory word or flag changes and `done` stays 0, whatever the other inputs are.
- R11: `dbg_vdata` shows word `dbg_addr` of lane `dbg_lane`, and `dbg_flags` bit i shows flag `dbg_fidx` of lane i. Both follow their select inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Array can take an instruction |
| in_op | input | 4 | Opcode (see requirements; other values act as no-op) |
| in_dst | input | 4 | Destination vector index |
| in_src_a | input | 4 | First source vector index (also rotate source) |
| in_src_b | input | 4 | Second source vector index |
| in_fdst | input | 3 | Destination flag index |
| in_fsa | input | 3 | First source flag index |
| in_fsb | input | 3 | Second source flag index |
| in_pred_en | input | 1 | Enable predication |
| in_pred_sel | input | 3 | Predicate flag index |
| in_imm | input | 16 | Immediate value or flag mask |
| in_rot | input | 3 | Rotate amount k |
| done | output | 1 | One-cycle pulse when an instruction's results are visible |
| dbg_lane | input | 3 | Debug lane select |
| dbg_addr | input | 4 | Debug word select |
| dbg_vdata | output | 16 | Selected word |
| dbg_fidx | input | 3 | Debug flag select |
| dbg_flags | output | 8 | Selected flag across all lanes |

## Verification
The bench targets the following corner cases. For each, it states what a faulty design would produce.

- Carry out of 0xFFFF+1 and borrow out of 0-1. A design that drops the 17th bit, or that inverts the borrow sense, leaves the wrong flag pattern.
- Predicated writes under sparse masks. An unmasked write would overwrite lanes whose flag is 0. A mask that gates only the vector write would still change the destination flag.
- Rotates by 0, 1, 3 and 7, including rotating a vector into itself. A shift in the wrong direction, or an off-by-one in the step count, moves each element to the wrong lane. An early release of `in_ready` cuts the rotation short.
- Idle cycles driven with live-looking opcode fields. These expose a design that executes without a handshake.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_FAND = 4'd3,
    OP_FOR  = 4'd4,
    OP_LDI  = 4'd5,
    OP_IDX  = 4'd6,
    OP_FLDI = 4'd7,
    OP_ROT  = 4'd8
  } opcode_e;

  typedef enum logic {
    SQ_IDLE  = 1'b0,
    SQ_SHIFT = 1'b1
  } seq_state_e;

endpackage

// File: rtl/simd_seq.sv
module simd_seq
  import simd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 16,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  opcode_e       op,
  input  logic [AW-1:0] dst,
  input  logic [LW-1:0] rot_amt,
  output logic          done,
  output logic          exec,
  output logic          rot_load,
  output logic          rot_shift,
  output logic          rot_last,
  output logic [AW-1:0] rot_dst
);

  seq_state_e    state;
  logic [LW-1:0] cnt;
  logic          accept;
  logic          long_rot;

  assign in_ready  = (state == SQ_IDLE);
  assign accept    = in_valid && in_ready;
  assign long_rot  = (op == OP_ROT) && (rot_amt != '0);
  assign exec      = accept && !long_rot;
  assign rot_load  = accept && long_rot;
  assign rot_shift = (state == SQ_SHIFT);
  assign rot_last  = rot_shift && (cnt == LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      rot_dst <= '0;
    end else begin
      done <= exec || rot_last;
      if (rot_load) begin
        state   <= SQ_SHIFT;
        cnt     <= rot_amt;
        rot_dst <= dst;
      end else if (rot_shift) begin
        cnt <= cnt - LW'(1);
        if (rot_last) state <= SQ_IDLE;
      end
    end
  end

  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !long_rot) |=> (done && in_ready)); // R2
  AST_ROT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && long_rot) |=> (!in_ready && !done)); // R9
  AST_SHIFT_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (cnt != '0)); // R9
  AST_ROT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && cnt == LW'(1)) |=> (in_ready && done)); // R9
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !done); // R10

endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int LANE_ID = 0,
  parameter int DEPTH   = 16,
  parameter int NFLAGS  = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW = (NFLAGS > 1) ? $clog2(NFLAGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  opcode_e           op,
  input  logic [AW-1:0]     dst,
  input  logic [AW-1:0]     src_a,
  input  logic [AW-1:0]     src_b,
  input  logic [FW-1:0]     fdst,
  input  logic [FW-1:0]     fsa,
  input  logic [FW-1:0]     fsb,
  input  logic              pred_en,
  input  logic [FW-1:0]     pred_sel,
  input  logic [WORD_W-1:0] imm,
  input  logic              exec,
  input  logic              rot_load,
  input  logic              rot_shift,
  input  logic              rot_last,
  input  logic [AW-1:0]     rot_dst,
  input  logic [WORD_W-1:0] right_in,
  output logic [WORD_W-1:0] rreg_out,
  input  logic [AW-1:0]     dbg_addr,
  output logic [WORD_W-1:0] dbg_vdata,
  input  logic [FW-1:0]     dbg_fidx,
  output logic              dbg_flag
);

  localparam int              MASK_BIT = LANE_ID % WORD_W;
  localparam logic [WORD_W-1:0] ID_WORD = WORD_W'(LANE_ID);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [NFLAGS-1:0] flg;
  logic [WORD_W-1:0] rreg;
  logic [WORD_W-1:0] va, vb, vd;
  logic [WORD_W:0]   sum_w, dif_w;
  logic              pred;
  logic              vwrite, fwrite, fval;
  logic [WORD_W-1:0] wval;

  assign va    = mem[src_a];
  assign vb    = mem[src_b];
  assign vd    = mem[dst];
  assign sum_w = {1'b0, va} + {1'b0, vb};
  assign dif_w = {1'b0, va} - {1'b0, vb};
  assign pred  = !pred_en || flg[pred_sel];

  always_comb begin
    vwrite = 1'b0;
    fwrite = 1'b0;
    wval   = va;
    fval   = 1'b0;
    case (op)
      OP_ADD: begin
        vwrite = 1'b1;
        wval   = sum_w[WORD_W-1:0];
        fwrite = 1'b1;
        fval   = sum_w[WORD_W];
      end
      OP_SUB: begin
        vwrite = 1'b1;
        wval   = dif_w[WORD_W-1:0];
        fwrite = 1'b1;
        fval   = dif_w[WORD_W];
      end
      OP_FAND: begin
        fwrite = 1'b1;
        fval   = flg[fsa] & flg[fsb];
      end
      OP_FOR: begin
        fwrite = 1'b1;
        fval   = flg[fsa] | flg[fsb];
      end
      OP_LDI: begin
        vwrite = 1'b1;
        wval   = imm;
      end
      OP_IDX: begin
        vwrite = 1'b1;
        wval   = ID_WORD;
      end
      OP_FLDI: begin
        fwrite = 1'b1;
        fval   = imm[MASK_BIT];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      flg  <= '0;
      rreg <= '0;
    end else begin
      if (exec && pred && vwrite) mem[dst] <= wval;
      if (exec && pred && fwrite) flg[fdst] <= fval;
      if (exec && op == OP_ROT) mem[dst] <= va;
      if (rot_load)       rreg <= va;
      else if (rot_shift) rreg <= right_in;
      if (rot_last) mem[rot_dst] <= right_in;
    end
  end

  assign rreg_out  = rreg;
  assign dbg_vdata = mem[dbg_addr];
  assign dbg_flag  = flg[dbg_fidx];

  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && vwrite && pred_en && !flg[pred_sel]) |=> (mem[$past(dst)] == $past(vd))); // R7
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && pred && op == OP_ADD) |=>
      ({flg[$past(fdst)], mem[$past(dst)]} == ({1'b0, $past(va)} + {1'b0, $past(vb)}))); // R3
  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && pred && op == OP_SUB) |=> (flg[$past(fdst)] == ($past(va) < $past(vb)))); // R4

endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
  import simd_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DEPTH  = 16,
  parameter int NFLAGS = 8,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW = (NFLAGS > 1) ? $clog2(NFLAGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [AW-1:0]     in_dst,
  input  logic [AW-1:0]     in_src_a,
  input  logic [AW-1:0]     in_src_b,
  input  logic [FW-1:0]     in_fdst,
  input  logic [FW-1:0]     in_fsa,
  input  logic [FW-1:0]     in_fsb,
  input  logic              in_pred_en,
  input  logic [FW-1:0]     in_pred_sel,
  input  logic [15:0]       in_imm,
  input  logic [LW-1:0]     in_rot,
  output logic              done,
  input  logic [LW-1:0]     dbg_lane,
  input  logic [AW-1:0]     dbg_addr,
  output logic [15:0]       dbg_vdata,
  input  logic [FW-1:0]     dbg_fidx,
  output logic [LANES-1:0]  dbg_flags
);

  opcode_e       op_e;
  logic          exec, rot_load, rot_shift, rot_last;
  logic [AW-1:0] rot_dst;

  logic [WORD_W-1:0] lane_rreg [LANES];
  logic [WORD_W-1:0] lane_data [LANES];

  assign op_e = opcode_e'(in_op);

  simd_seq #(.LANES(LANES), .DEPTH(DEPTH)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op        (op_e),
    .dst       (in_dst),
    .rot_amt   (in_rot),
    .done      (done),
    .exec      (exec),
    .rot_load  (rot_load),
    .rot_shift (rot_shift),
    .rot_last  (rot_last),
    .rot_dst   (rot_dst)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simd_lane #(.LANE_ID(g), .DEPTH(DEPTH), .NFLAGS(NFLAGS)) lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op_e),
      .dst       (in_dst),
      .src_a     (in_src_a),
      .src_b     (in_src_b),
      .fdst      (in_fdst),
      .fsa       (in_fsa),
      .fsb       (in_fsb),
      .pred_en   (in_pred_en),
      .pred_sel  (in_pred_sel),
      .imm       (in_imm),
      .exec      (exec),
      .rot_load  (rot_load),
      .rot_shift (rot_shift),
      .rot_last  (rot_last),
      .rot_dst   (rot_dst),
      .right_in  (lane_rreg[(g + 1) % LANES]),
      .rreg_out  (lane_rreg[g]),
      .dbg_addr  (dbg_addr),
      .dbg_vdata (lane_data[g]),
      .dbg_fidx  (dbg_fidx),
      .dbg_flag  (dbg_flags[g])
    );
  end

  assign dbg_vdata = lane_data[dbg_lane];

endmodule

// File: tb/simd_lane_array_tb_top.sv
`timescale 1ns/1ps
module simd_lane_array_tb_top;

  localparam int LANES = 8, DEPTH = 16, NFLAGS = 8;
  localparam int LW = 3, AW = 4, FW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic in_valid = 1'b0, in_ready, in_pred_en = 1'b0, done;
  logic [3:0] in_op = '0;
  logic [AW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0, dbg_addr = '0;
  logic [FW-1:0] in_fdst = '0, in_fsa = '0, in_fsb = '0, in_pred_sel = '0, dbg_fidx = '0;
  logic [15:0] in_imm = '0, dbg_vdata;
  logic [LW-1:0] in_rot = '0, dbg_lane = '0;
  logic [LANES-1:0] dbg_flags;

  simd_lane_array #(.LANES(LANES), .DEPTH(DEPTH), .NFLAGS(NFLAGS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_fdst(in_fdst), .in_fsa(in_fsa), .in_fsb(in_fsb), .in_pred_en(in_pred_en),
    .in_pred_sel(in_pred_sel), .in_imm(in_imm), .in_rot(in_rot), .done(done),
    .dbg_lane(dbg_lane), .dbg_addr(dbg_addr), .dbg_vdata(dbg_vdata),
    .dbg_fidx(dbg_fidx), .dbg_flags(dbg_flags)
  );

  int checks = 0, fails = 0;
  logic [15:0] m_mem [LANES][DEPTH];
  logic        m_flg [LANES][NFLAGS];
  int   exp_busy = 0;
  logic exp_done = 1'b0;
  logic mon_on = 1'b0;
  logic finished = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural handshake model, advanced on every clock
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_busy <= 0;
      exp_done <= 1'b0;
    end else if (exp_busy > 0) begin
      exp_busy <= exp_busy - 1;
      exp_done <= (exp_busy == 1);
    end else if (in_valid) begin
      if (in_op == 4'd8 && in_rot != 0) begin
        exp_busy <= int'(in_rot);
        exp_done <= 1'b0;
      end else exp_done <= 1'b1;
    end else exp_done <= 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      chk("R9", "in_ready", in_ready, exp_busy == 0);
      chk("R2", "done", done, exp_done);
    end
  end

  task automatic check_all(input string tag);
    for (int l = 0; l < LANES; l++) begin
      for (int a = 0; a < DEPTH; a++) begin
        dbg_lane = LW'(l);
        dbg_addr = AW'(a);
        #0.005;
        chk(tag, $sformatf("lane%0d word%0d", l, a), dbg_vdata, m_mem[l][a]);
      end
    end
    for (int f = 0; f < NFLAGS; f++) begin
      logic [LANES-1:0] ev;
      for (int l = 0; l < LANES; l++) ev[l] = m_flg[l][f];
      dbg_fidx = FW'(f);
      #0.005;
      chk(tag, $sformatf("flag%0d", f), dbg_flags, ev);
    end
  endtask

  task automatic model(input int op, input int dst, input int sa, input int sb, input int fd,
                       input int fa, input int fb, input int pe, input int ps, input int imm, input int rot);
    logic [15:0] col [LANES];
    for (int l = 0; l < LANES; l++) col[l] = m_mem[l][sa];
    for (int l = 0; l < LANES; l++) begin
      bit p;
      logic [16:0] r;
      p = (pe == 0) || m_flg[l][ps];
      case (op)
        1: if (p) begin
             r = {1'b0, m_mem[l][sa]} + {1'b0, m_mem[l][sb]};
             m_mem[l][dst] = r[15:0]; m_flg[l][fd] = r[16];
           end
        2: if (p) begin
             r = {1'b0, m_mem[l][sa]} - {1'b0, m_mem[l][sb]};
             m_flg[l][fd] = (m_mem[l][sa] < m_mem[l][sb]); m_mem[l][dst] = r[15:0];
           end
        3: if (p) m_flg[l][fd] = m_flg[l][fa] & m_flg[l][fb];
        4: if (p) m_flg[l][fd] = m_flg[l][fa] | m_flg[l][fb];
        5: if (p) m_mem[l][dst] = 16'(imm);
        6: if (p) m_mem[l][dst] = 16'(l);
        7: if (p) m_flg[l][fd] = imm[l % 16];
        8: m_mem[l][dst] = col[(l + rot) % LANES];
        default: ;
      endcase
    end
  endtask

  task automatic issue(input int op, input int dst, input int sa, input int sb, input int fd,
                       input int fa, input int fb, input int pe, input int ps, input int imm, input int rot);
    @(negedge clk);
    in_op = 4'(op); in_dst = AW'(dst); in_src_a = AW'(sa); in_src_b = AW'(sb);
    in_fdst = FW'(fd); in_fsa = FW'(fa); in_fsb = FW'(fb); in_pred_en = pe[0];
    in_pred_sel = FW'(ps); in_imm = 16'(imm); in_rot = LW'(rot);
    in_valid = 1'b1;
    model(op, dst, sa, sb, fd, fa, fb, pe, ps, imm, rot);
    @(negedge clk);
    in_valid = 1'b0;
    while (in_ready !== 1'b1) @(negedge clk);
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) begin
      for (int a = 0; a < DEPTH; a++) m_mem[l][a] = '0;
      for (int f = 0; f < NFLAGS; f++) m_flg[l][f] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready after reset", in_ready, 1);
    chk("R1", "done after reset", done, 0);
    check_all("R1");
    mon_on = 1'b1;

    // R6 loads
    issue(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    issue(5, 1, 0, 0, 0, 0, 0, 0, 0, 16'hFFFF, 0);
    issue(5, 2, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    check_all("R6");
    // R3 add with carry wrap and no carry
    issue(1, 3, 1, 2, 0, 0, 0, 0, 0, 0, 0);
    issue(1, 4, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    check_all("R3");
    // R4 subtract with borrow in lane 0 only
    issue(2, 5, 0, 2, 2, 0, 0, 0, 0, 0, 0);
    check_all("R4");
    // R6 flag masks, R5 flag logic
    issue(7, 0, 0, 0, 3, 0, 0, 0, 0, 16'h00A5, 0);
    issue(7, 0, 0, 0, 4, 0, 0, 0, 0, 16'h0F0F, 0);
    issue(3, 0, 0, 0, 5, 3, 4, 0, 0, 0, 0);
    issue(4, 0, 0, 0, 6, 3, 4, 0, 0, 0, 0);
    check_all("R5");
    // R7 predicated execution
    issue(2, 0, 0, 2, 7, 0, 0, 1, 3, 0, 0);
    issue(5, 6, 0, 0, 0, 0, 0, 1, 4, 16'h1234, 0);
    issue(1, 9, 1, 1, 6, 0, 0, 1, 5, 0, 0);
    issue(7, 0, 0, 0, 2, 0, 0, 1, 4, 16'hFFFF, 0);
    check_all("R7");
    // R8 rotations, R9 timing (monitored each clock)
    issue(8, 7, 4, 0, 0, 0, 0, 0, 0, 0, 3);
    check_all("R8");
    issue(8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    issue(8, 4, 4, 0, 0, 0, 0, 1, 3, 0, 7);
    check_all("R8");
    issue(8, 8, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R9");
    // R10 idle with live-looking fields
    @(negedge clk);
    in_valid = 1'b0; in_op = 4'd5; in_dst = 4'd0; in_imm = 16'hDEAD; in_fdst = 3'd0;
    repeat (4) @(negedge clk);
    chk("R10", "done while idle", done, 0);
    in_op = 4'd8; in_rot = 3'd5;
    repeat (3) @(negedge clk);
    chk("R10", "in_ready while idle", in_ready, 1);
    check_all("R10");
    // R11 combinational debug read
    check_all("R11");
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule